// File: doc/BRIEF.md
# Display-Throttled Write FIFO Occupancy Model

This block tracks how many CPU data-port writes are waiting to reach video memory while the picture is being drawn. Up to four words may be queued. Nothing is actually stored here; the block keeps an occupancy count. One entry retires each time a fixed number of master-cycle ticks passes. The block reports that count to the CPU side as a full flag and an empty flag. When the CPU writes into a queue that is already full, the block asserts a stall output that holds the CPU until a slot frees.

The retire interval depends on the horizontal mode: 190 ticks in the wide mode and 214 in the narrow mode. The interval doubles while the write target is video RAM, because that memory takes each word as two byte accesses. Throttling applies only during active display. During vertical blank, or while the display is switched off, writes pass straight through and leave the count alone.

The control is a four-state machine:
- `ST_EMPTY`: no entries.
- `ST_PARTIAL`: one to three entries.
- `ST_FULL`: four entries.
- `ST_STALL`: four entries plus one write held back.

The transitions are:
- fill, `ST_EMPTY` to `ST_PARTIAL`, on a throttled write.
- top-off, `ST_PARTIAL` to `ST_FULL`, when the count reaches four.
- overflow, `ST_FULL` to `ST_STALL`, on a write with no retire in the same cycle.
- release, `ST_STALL` to `ST_FULL`, when a retire frees a slot and the held write takes it.
- ease, `ST_FULL` to `ST_PARTIAL`, on a retire without a write.
- drain-out, `ST_PARTIAL` to `ST_EMPTY`, when the last entry retires.

Top module: `dispwr_fifo`

## Requirements
- R1: After reset `fifo_empty` is 1, `fifo_full` is 0 and `cpu_stall` is 0.
- R2: A write strobe counts only when `vblank` is 0 and `disp_en` is 1. Otherwise the occupancy does not change and `fifo_empty` stays 1 if it was 1.
- R3: With `wr_vram` at 0, an entry retires every 190 ticked cycles when `wide_mode` is 1 and every 214 ticked cycles when `wide_mode` is 0.
- R4: While `wr_vram` is 1, the retire interval is twice the value given in R3.
- R5: A throttled write into an empty queue clears `fifo_empty` at the next clock edge. It also restarts the retire timer, so the first retire happens on the interval-th ticked edge after that write.
- R6: `fifo_full` is 1 exactly when four entries are held. It drops at the edge where a retire leaves three.
- R7: A throttled write while four entries are held, with no retire at the same edge, raises `cpu_stall` from the next edge. `cpu_stall` stays high until the next retire. At that edge the held write is accepted, `cpu_stall` falls and `fifo_full` stays 1.
- R8: Write strobes that arrive while `cpu_stall` is 1 are ignored.
- R9: The retire reference advances by whole intervals. Ticks counted beyond one interval carry over to the next retire; they are not discarded when the interval changes.
- R10: The timer advances only in cycles where `mc_tick` is 1. Without ticks nothing retires.
- R11: The count never goes below zero. `fifo_empty` sets at the edge where the last entry retires and stays set while ticks continue. A later write again waits a full interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | 1 | One-cycle CPU data-port write strobe |
| wr_vram | input | 1 | Current write target is video RAM (byte-wide accesses) |
| wide_mode | input | 1 | 1 selects the wide horizontal mode, 0 the narrow mode |
| vblank | input | 1 | Vertical blank in progress |
| disp_en | input | 1 | Display enable |
| mc_tick | input | 1 | Master-cycle tick that advances the retire timer |
| fifo_full | output | 1 | Four entries held |
| fifo_empty | output | 1 | No entries held |
| cpu_stall | output | 1 | CPU must wait; a write is held back |

## Verification
Bursts of one to four back-to-back writes are timed until the empty flag returns. The expected wait is the burst length times the interval, less the cycles the burst itself took. This is tried for each combination of mode and video-RAM target, which separates the 190 and 214 base values and shows whether the doubling is applied. The same bursts issued during vertical blank and with the display off must leave the empty flag untouched, which separates throttled writes from bypassed ones. Directed sequences cover the following:
- a fifth write, to check the stall and its release at the first retire;
- a strobe during the stall;
- held-off ticks;
- an interval change in mid-count, which tells carried-over ticks apart from a restarted timer.

// File: rtl/dwf_pkg.sv
package dwf_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY   = 2'd0,
        ST_PARTIAL = 2'd1,
        ST_FULL    = 2'd2,
        ST_STALL   = 2'd3
    } dwf_state_e;

endpackage

// File: rtl/dwf_interval.sv
module dwf_interval #(
    parameter int WIDE_IV     = 190,
    parameter int NARROW_IV   = 214,
    parameter bit VRAM_DOUBLE = 1'b1,
    parameter int IVW         = 9
) (
    input  logic           wide_mode,
    input  logic           wr_vram,
    output logic [IVW-1:0] iv
);

    logic [IVW-1:0] base_iv;

    // mode picks the base spacing between retires
    assign base_iv = wide_mode ? IVW'(WIDE_IV) : IVW'(NARROW_IV);

    generate
        if (VRAM_DOUBLE) begin : g_dbl
            // a word into byte-wide memory costs two accesses
            assign iv = wr_vram ? (base_iv << 1) : base_iv;
        end else begin : g_flat
            logic unused_vram;
            assign unused_vram = wr_vram;
            assign iv = base_iv;
        end
    endgenerate

endmodule

// File: rtl/dwf_drain_timer.sv
module dwf_drain_timer #(
    parameter int IVW = 9
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           mc_tick,
    input  logic           active,
    input  logic           restart,
    input  logic [IVW-1:0] iv,
    output logic           drain
);

    logic [IVW-1:0] elapsed_q;
    logic [IVW-1:0] elapsed_d;
    logic [IVW:0]   bumped;

    assign bumped = {1'b0, elapsed_q} + {{IVW{1'b0}}, 1'b1};
    assign drain  = mc_tick && active && (bumped >= {1'b0, iv});

    always_comb begin
        elapsed_d = elapsed_q;
        if (restart) begin
            elapsed_d = '0;
        end else if (mc_tick && active) begin
            if (drain) begin
                // move reference by one whole interval, keep the remainder
                elapsed_d = IVW'(bumped - {1'b0, iv});
            end else begin
                elapsed_d = bumped[IVW-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            elapsed_q <= '0;
        end else begin
            elapsed_q <= elapsed_d;
        end
    end

endmodule

// File: rtl/dwf_fsm.sv
module dwf_fsm
    import dwf_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int CW    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_go,
    input  logic drain,
    output logic active,
    output logic restart,
    output logic fifo_full,
    output logic fifo_empty,
    output logic cpu_stall
);

    dwf_state_e      state_q;
    dwf_state_e      state_d;
    logic [CW-1:0]   occ_q;
    logic [CW-1:0]   occ_d;
    logic            accept;
    logic            block;

    // transition decision
    always_comb begin
        accept = 1'b0;
        block  = 1'b0;
        unique case (state_q)
            ST_EMPTY: begin
                if (wr_go) accept = 1'b1;
            end
            ST_PARTIAL: begin
                if (wr_go) accept = 1'b1;
            end
            ST_FULL: begin
                if (wr_go) begin
                    if (drain) accept = 1'b1;
                    else       block  = 1'b1;
                end
            end
            ST_STALL: begin
                // held write takes the slot freed by a retire
                if (drain) accept = 1'b1;
            end
            default: begin
                accept = 1'b0;
            end
        endcase
    end

    assign occ_d = occ_q - CW'(drain) + CW'(accept);

    always_comb begin
        if (block) begin
            state_d = ST_STALL;
        end else if (state_q == ST_STALL && !drain) begin
            state_d = ST_STALL;
        end else if (occ_d == '0) begin
            state_d = ST_EMPTY;
        end else if (occ_d == CW'(DEPTH)) begin
            state_d = ST_FULL;
        end else begin
            state_d = ST_PARTIAL;
        end
    end

    assign active  = (state_q != ST_EMPTY);
    assign restart = ((state_q == ST_EMPTY) && accept) || (occ_d == '0);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
            occ_q   <= '0;
        end else begin
            state_q <= state_d;
            occ_q   <= occ_d;
        end
    end

    // outputs
    always_comb begin
        fifo_full  = 1'b0;
        fifo_empty = 1'b0;
        cpu_stall  = 1'b0;
        unique case (state_q)
            ST_EMPTY:   fifo_empty = 1'b1;
            ST_PARTIAL: fifo_empty = 1'b0;
            ST_FULL:    fifo_full  = 1'b1;
            ST_STALL: begin
                fifo_full = 1'b1;
                cpu_stall = 1'b1;
            end
            default:    fifo_empty = 1'b0;
        endcase
    end

endmodule

// File: rtl/dispwr_fifo.sv
module dispwr_fifo #(
    parameter int DEPTH       = 4,
    parameter int WIDE_IV     = 190,
    parameter int NARROW_IV   = 214,
    parameter bit VRAM_DOUBLE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_stb,
    input  logic wr_vram,
    input  logic wide_mode,
    input  logic vblank,
    input  logic disp_en,
    input  logic mc_tick,
    output logic fifo_full,
    output logic fifo_empty,
    output logic cpu_stall
);

    localparam int MAX_IV = (WIDE_IV > NARROW_IV) ? WIDE_IV : NARROW_IV;
    localparam int IVW    = $clog2(2 * MAX_IV + 1);
    localparam int CW     = $clog2(DEPTH + 1);

    logic           throttled;
    logic           wr_go;
    logic [IVW-1:0] iv;
    logic           drain;
    logic           active;
    logic           restart;

    // throttling only while the picture is being drawn
    assign throttled = !vblank && disp_en;
    assign wr_go     = wr_stb && throttled;

    dwf_interval #(
        .WIDE_IV    (WIDE_IV),
        .NARROW_IV  (NARROW_IV),
        .VRAM_DOUBLE(VRAM_DOUBLE),
        .IVW        (IVW)
    ) u_iv (
        .wide_mode(wide_mode),
        .wr_vram  (wr_vram),
        .iv       (iv)
    );

    dwf_drain_timer #(
        .IVW(IVW)
    ) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .mc_tick(mc_tick),
        .active (active),
        .restart(restart),
        .iv     (iv),
        .drain  (drain)
    );

    dwf_fsm #(
        .DEPTH(DEPTH),
        .CW   (CW)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_go     (wr_go),
        .drain     (drain),
        .active    (active),
        .restart   (restart),
        .fifo_full (fifo_full),
        .fifo_empty(fifo_empty),
        .cpu_stall (cpu_stall)
    );

endmodule

// File: rtl/dispwr_fifo_chk.sv
module dispwr_fifo_chk (
    input logic clk,
    input logic rst_n,
    input logic wr_stb,
    input logic vblank,
    input logic disp_en,
    input logic mc_tick,
    input logic fifo_full,
    input logic fifo_empty,
    input logic cpu_stall
);

    // R6
    full_empty_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_full && fifo_empty));

    // R7
    stall_needs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_stall |-> fifo_full);

    // R2
    bypass_keeps_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_empty && (vblank || !disp_en)) |=> fifo_empty);

    // R5
    fill_clears_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_empty && wr_stb && !vblank && disp_en) |=> !fifo_empty);

    // R10
    no_tick_no_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mc_tick && !fifo_empty) |=> !fifo_empty);

    // R10
    no_tick_keeps_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mc_tick && cpu_stall) |=> cpu_stall);

    // R6
    no_tick_keeps_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mc_tick && fifo_full) |=> fifo_full);

endmodule

bind dispwr_fifo dispwr_fifo_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_stb    (wr_stb),
    .vblank    (vblank),
    .disp_en   (disp_en),
    .mc_tick   (mc_tick),
    .fifo_full (fifo_full),
    .fifo_empty(fifo_empty),
    .cpu_stall (cpu_stall)
);

// File: tb/dispwr_fifo_bench.sv
`timescale 1ns/1ps
module dispwr_fifo_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_stb = 1'b0;
    logic wr_vram = 1'b0;
    logic wide_mode = 1'b1;
    logic vblank = 1'b0;
    logic disp_en = 1'b1;
    logic mc_tick = 1'b1;
    logic fifo_full, fifo_empty, cpu_stall;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    dispwr_fifo u_dispwr_fifo (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_vram(wr_vram),
        .wide_mode(wide_mode), .vblank(vblank), .disp_en(disp_en),
        .mc_tick(mc_tick), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
        .cpu_stall(cpu_stall)
    );

    // [7] wide [6] vram [5] vblank [4] disp_en [3:1] burst length [0] full expected
    localparam logic [7:0] VEC [6] = '{
        8'b1_0_0_1_001_0,   // R3 wide, one write
        8'b0_0_0_1_010_0,   // R3 narrow, two writes
        8'b1_1_0_1_011_0,   // R4 wide to video RAM, three writes
        8'b0_1_0_1_100_1,   // R4 R6 narrow to video RAM, four writes
        8'b1_0_1_1_011_0,   // R2 vertical blank
        8'b1_0_0_0_100_0    // R2 display off
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic wait_empty(output int w);
        w = 0;
        while (!fifo_empty && w < 5000) begin
            step(1);
            w++;
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        int w;
        int iv;
        int n;
        bit act;
        @(negedge clk);
        step(3);
        // R1 reset state
        check(fifo_empty == 1'b1, "R1 empty", fifo_empty, 1);
        check(fifo_full == 1'b0, "R1 full", fifo_full, 0);
        check(cpu_stall == 1'b0, "R1 stall", cpu_stall, 0);
        rst_n = 1'b1;
        step(2);
        check(fifo_empty == 1'b1, "R1 empty after release", fifo_empty, 1);

        // vector table
        for (int k = 0; k < 6; k++) begin
            wide_mode = VEC[k][7];
            wr_vram   = VEC[k][6];
            vblank    = VEC[k][5];
            disp_en   = VEC[k][4];
            n         = int'(VEC[k][3:1]);
            act       = !VEC[k][5] && VEC[k][4];
            iv        = (VEC[k][7] ? 190 : 214) * (VEC[k][6] ? 2 : 1);
            for (int j = 0; j < n; j++) begin
                wr_stb = 1'b1;
                step(1);
                if (j == 0 && act)
                    check(fifo_empty == 1'b0, "R5 empty clears", fifo_empty, 0);
            end
            wr_stb = 1'b0;
            check(fifo_full == VEC[k][0], "R6 full after burst", fifo_full, int'(VEC[k][0]));
            if (act) begin
                wait_empty(w);
                check(w == n * iv - (n - 1), VEC[k][6] ? "R4 doubled interval" : "R3 interval",
                      w, n * iv - (n - 1));
            end else begin
                check(fifo_empty == 1'b1, "R2 bypass keeps empty", fifo_empty, 1);
            end
            vblank = 1'b0;
            disp_en = 1'b1;
            step(2);
        end

        // R7 overflow stall and release; R8 strobe during stall
        wide_mode = 1'b1;
        wr_vram = 1'b0;
        for (int j = 0; j < 5; j++) begin
            wr_stb = 1'b1;
            step(1);
        end
        wr_stb = 1'b0;
        check(cpu_stall == 1'b1, "R7 stall raised", cpu_stall, 1);
        wr_stb = 1'b1;
        step(1);
        wr_stb = 1'b0;
        step(184);
        check(cpu_stall == 1'b1, "R7 stall held", cpu_stall, 1);
        step(1);
        check(cpu_stall == 1'b0, "R7 stall released", cpu_stall, 0);
        check(fifo_full == 1'b1, "R7 held write accepted", fifo_full, 1);
        step(189);
        check(fifo_full == 1'b1, "R6 still full", fifo_full, 1);
        step(1);
        check(fifo_full == 1'b0, "R6 full clears", fifo_full, 0);
        step(569);
        check(fifo_empty == 1'b0, "R8 strobe ignored, not yet empty", fifo_empty, 0);
        step(1);
        check(fifo_empty == 1'b1, "R8 strobe ignored, empty on time", fifo_empty, 1);

        // R10 ticks gate the timer
        mc_tick = 1'b0;
        wr_stb = 1'b1;
        step(1);
        wr_stb = 1'b0;
        step(500);
        check(fifo_empty == 1'b0, "R10 no retire without tick", fifo_empty, 0);
        mc_tick = 1'b1;
        step(189);
        check(fifo_empty == 1'b0, "R10 not early", fifo_empty, 0);
        step(1);
        check(fifo_empty == 1'b1, "R10 retire after ticks", fifo_empty, 1);

        // R9 carry across an interval change
        wr_vram = 1'b1;
        wr_stb = 1'b1;
        step(2);
        wr_stb = 1'b0;
        step(299);
        check(fifo_empty == 1'b0, "R9 before change", fifo_empty, 0);
        wr_vram = 1'b0;
        step(79);
        check(fifo_empty == 1'b0, "R9 carry not early", fifo_empty, 0);
        step(1);
        check(fifo_empty == 1'b1, "R9 carried ticks", fifo_empty, 1);

        // R11 floor at zero
        step(50);
        check(fifo_empty == 1'b1, "R11 stays empty", fifo_empty, 1);
        wr_stb = 1'b1;
        step(1);
        wr_stb = 1'b0;
        wait_empty(w);
        check(w == 190, "R11 full interval after idle", w, 190);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule